// File: doc/BRIEF.md
# Shared-Memory Endpoint Buffer Controller

This block sits between a USB transaction engine and a CPU. Data moves through two buffer memories. The CPU fills the transmit memory and the transaction engine reads it. The transaction engine fills the receive memory and the CPU reads it. Each endpoint direction is described by a pointer and a length into the right memory, not by a FIFO.

Four bitmask registers control the endpoints: arm, data-toggle, stall and pending. Each of them holds one bit per endpoint direction. The CPU loads a pointer and a length for a device-to-host transfer, or relies on the receive pointer for a host-to-device transfer. It then sets the arm bit. The controller answers the next matching transaction, moves the pointer, updates the length, clears the arm bit, flips the toggle and raises pending. While pending is set, the endpoint answers NAK. Protocol decoding and CRC belong to the transaction engine. That engine presents each transaction as a token strobe, a byte stream and an end or acknowledge strobe.

Top module: `epbuf_ctrl`

## Requirements

- R1: After reset, the following are all zero:
  - the arm, toggle, stall and pending masks
  - every transmit pointer and length, and every receive length
  - the irq, the response strobe and the transmit valid

  The receive pointer of endpoint e resets to e*(MEM_DEPTH/NUM_EP).
- R2: Mask bit 2e+1 controls endpoint e device-to-host (IN). Mask bit 2e controls endpoint e host-to-device (OUT). The register addresses are:
  - arm at 0, toggle at 1, stall at 2, pending at 3
  - for endpoint e, at 8+4e+k: k=0 is the IN pointer, 1 the IN length, 2 the OUT pointer, 3 the OUT length
- R3: A token to an endpoint direction whose stall bit is set produces a STALL response. The response is code 3 on usb_resp, strobed one cycle after the token. Stall wins over the arm and pending state.
- R4: A token to a direction that is not armed, or whose pending bit is set, produces a NAK (code 2). Host-to-device data sent after such a NAK is ignored: the receive memory, the OUT pointer, the OUT length and all masks are unchanged.
- R5: An armed IN token streams IN-length bytes from the transmit memory, starting at the IN pointer and wrapping at MEM_DEPTH. usb_tx_last is high on the final byte, and a zero length sends no bytes. On usb_host_ack the following happen:
  - the pointer advances by the length
  - the length becomes 0
  - arm clears and pending sets
- R6: An armed OUT token stores the received bytes at consecutive receive-memory addresses, starting at the OUT pointer. On usb_rx_end the controller answers ACK (code 1) one cycle later, sets the OUT length to the byte count and advances the OUT pointer by it. Arm clears and pending sets.
- R7: usb_data1 shows the toggle bit of the active direction during a transaction. The toggle bit inverts each time a transfer completes.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it. usb_irq is high while any pending bit is set.
- R9: usb_abort during a transaction returns the controller to idle without committing. Pointer, length, arm, toggle and pending are unchanged, and a later token repeats the transfer from its start.
- R10: Bytes of an OUT packet beyond MAX_PKT are dropped, so the committed OUT length saturates at MAX_PKT.
- R11: The CPU can write and read back the IN pointer and length. The OUT pointer and length are read-only, so CPU writes to them have no effect.
- R12: A token naming an endpoint number at or above NUM_EP produces a NAK.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 9 | Register write data |
| reg_rdata | output | 9 | Register read data (combinational) |
| cmem_we | input | 1 | CPU write strobe to transmit memory |
| cmem_addr | input | 9 | CPU memory address |
| cmem_wdata | input | 8 | CPU write data |
| cmem_rdata | output | 8 | Receive memory data, one cycle after the address |
| usb_tok | input | 1 | Token strobe |
| usb_ep | input | 2 | Token endpoint number |
| usb_in | input | 1 | Token direction, 1 = device-to-host |
| usb_abort | input | 1 | Abandon the current transaction |
| usb_resp_valid | output | 1 | Handshake strobe |
| usb_resp | output | 2 | Handshake code: 1 ACK, 2 NAK, 3 STALL |
| usb_data1 | output | 1 | Data PID parity for the transaction (1 = DATA1) |
| usb_tx_valid | output | 1 | Transmit byte valid |
| usb_tx_data | output | 8 | Transmit byte |
| usb_tx_last | output | 1 | Final transmit byte |
| usb_tx_ready | input | 1 | Engine takes the transmit byte |
| usb_host_ack | input | 1 | Host acknowledged the IN data |
| usb_rx_valid | input | 1 | Received byte valid |
| usb_rx_data | input | 8 | Received byte |
| usb_rx_end | input | 1 | End of received data packet |
| usb_irq | output | 1 | OR of all pending bits |

## Verification

The checks assume that the transaction engine behaves in a fixed way:
- It raises usb_tok only between transactions.
- It raises usb_rx_end on a cycle with no byte.
- It gives usb_host_ack only after the last byte.

They also assume that the CPU does not rewrite an active endpoint's pointer or length mid-transfer. The bench drives each transaction as one strict sequence: token, bytes, then end or acknowledge. It changes registers only while the controller is idle, so the stimulus stays inside these assumptions. The stall and NAK properties assume a token is seen only while idle. Every bench token arrives in that state.

// File: rtl/epbuf_ctrl.sv
module epbuf_ctrl #(
  parameter int NUM_EP    = 3,
  parameter int MEM_DEPTH = 512,
  parameter int DW        = 8,
  parameter int MAX_PKT   = 64,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int PW   = $clog2(MEM_DEPTH),
  localparam int LW   = $clog2(MAX_PKT + 1),
  localparam int NB   = 2 * NUM_EP,
  localparam int RAW  = $clog2(8 + 4 * NUM_EP),
  localparam int RDW  = (PW > NB) ? ((PW > LW) ? PW : LW) : ((NB > LW) ? NB : LW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [RDW-1:0]  reg_wdata,
  output logic [RDW-1:0]  reg_rdata,
  input  logic            cmem_we,
  input  logic [PW-1:0]   cmem_addr,
  input  logic [DW-1:0]   cmem_wdata,
  output logic [DW-1:0]   cmem_rdata,
  input  logic            usb_tok,
  input  logic [EP_W-1:0] usb_ep,
  input  logic            usb_in,
  input  logic            usb_abort,
  output logic            usb_resp_valid,
  output logic [1:0]      usb_resp,
  output logic            usb_data1,
  output logic            usb_tx_valid,
  output logic [DW-1:0]   usb_tx_data,
  output logic            usb_tx_last,
  input  logic            usb_tx_ready,
  input  logic            usb_host_ack,
  input  logic            usb_rx_valid,
  input  logic [DW-1:0]   usb_rx_data,
  input  logic            usb_rx_end,
  output logic            usb_irq
);
  localparam int BW  = EP_W + 1;
  localparam int SEG = MEM_DEPTH / NUM_EP;
  localparam logic [1:0] RSP_ACK = 2'd1, RSP_NAK = 2'd2, RSP_STALL = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_TXW, ST_RX} st_t;

  logic [DW-1:0] tx_mem [MEM_DEPTH];
  logic [DW-1:0] rx_mem [MEM_DEPTH];

  st_t            state;
  logic [NB-1:0]  arm_q, tog_q, stall_q, pend_q, done;
  logic [PW-1:0]  in_ptr  [NUM_EP];
  logic [LW-1:0]  in_len  [NUM_EP];
  logic [PW-1:0]  out_ptr [NUM_EP];
  logic [LW-1:0]  out_len [NUM_EP];
  logic [EP_W-1:0] cur_ep;
  logic           cur_in;
  logic [LW-1:0]  cnt;
  logic           cur_odd;
  logic           resp_v_q;
  logic [1:0]     resp_q;

  logic           in_idle, tok_ok, rx_we;
  logic [BW-1:0]  tok_bit, cur_bit;
  logic [PW-1:0]  tx_addr;

  assign in_idle  = (state == ST_IDLE);
  assign tok_ok   = int'(usb_ep) < NUM_EP;
  assign tok_bit  = {usb_ep, usb_in};
  assign cur_bit  = {cur_ep, cur_in};
  assign tx_addr  = in_ptr[cur_ep] + PW'(cnt);
  assign rx_we    = (state == ST_RX) && usb_rx_valid && !usb_rx_end && !usb_abort
                    && (cnt < LW'(MAX_PKT));

  assign usb_tx_valid   = (state == ST_TX);
  assign usb_tx_data    = tx_mem[tx_addr];
  assign usb_tx_last    = usb_tx_valid && (cnt == in_len[cur_ep] - LW'(1));
  assign usb_data1      = cur_odd;
  assign usb_resp_valid = resp_v_q;
  assign usb_resp       = resp_q;
  assign usb_irq        = |pend_q;

  always_comb begin
    done = '0;
    if (!usb_abort && ((state == ST_TXW && usb_host_ack) || (state == ST_RX && usb_rx_end)))
      done[cur_bit] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (cmem_we) tx_mem[cmem_addr] <= cmem_wdata;
    if (rx_we) rx_mem[out_ptr[cur_ep] + PW'(cnt)] <= usb_rx_data;
    cmem_rdata <= rx_mem[cmem_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q   <= '0;
      tog_q   <= '0;
      stall_q <= '0;
      pend_q  <= '0;
    end else begin
      arm_q   <= ((reg_we && reg_addr == RAW'(0)) ? reg_wdata[NB-1:0] : arm_q) & ~done;
      tog_q   <= (((reg_we && reg_addr == RAW'(1)) ? reg_wdata[NB-1:0] : tog_q) & ~done)
                 | (~tog_q & done);
      stall_q <= (reg_we && reg_addr == RAW'(2)) ? reg_wdata[NB-1:0] : stall_q;
      pend_q  <= (pend_q & ~((reg_we && reg_addr == RAW'(3)) ? reg_wdata[NB-1:0] : '0)) | done;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < NUM_EP; e++) begin
      if (!rst_n) begin
        in_ptr[e]  <= '0;
        in_len[e]  <= '0;
        out_ptr[e] <= PW'(e * SEG);
        out_len[e] <= '0;
      end else begin
        if (reg_we && reg_addr == RAW'(8 + 4 * e)) in_ptr[e] <= reg_wdata[PW-1:0];
        if (reg_we && reg_addr == RAW'(9 + 4 * e)) in_len[e] <= reg_wdata[LW-1:0];
        if (|done && int'(cur_ep) == e) begin
          if (cur_in) begin
            in_ptr[e] <= in_ptr[e] + PW'(cnt);
            in_len[e] <= '0;
          end else begin
            out_ptr[e] <= out_ptr[e] + PW'(cnt);
            out_len[e] <= cnt;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_ep   <= '0;
      cur_in   <= 1'b0;
      cnt      <= '0;
      cur_odd  <= 1'b0;
      resp_v_q <= 1'b0;
      resp_q   <= 2'd0;
    end else begin
      resp_v_q <= 1'b0;
      case (state)
        ST_IDLE: if (usb_tok) begin
          if (!tok_ok) begin
            resp_v_q <= 1'b1; resp_q <= RSP_NAK;
          end else if (stall_q[tok_bit]) begin
            resp_v_q <= 1'b1; resp_q <= RSP_STALL;
          end else if (!arm_q[tok_bit] || pend_q[tok_bit]) begin
            resp_v_q <= 1'b1; resp_q <= RSP_NAK;
          end else begin
            cur_ep  <= usb_ep;
            cur_in  <= usb_in;
            cnt     <= '0;
            cur_odd <= tog_q[tok_bit];
            if (!usb_in)                     state <= ST_RX;
            else if (in_len[usb_ep] == '0)   state <= ST_TXW;
            else                             state <= ST_TX;
          end
        end
        ST_TX: begin
          if (usb_abort) state <= ST_IDLE;
          else if (usb_tx_ready) begin
            cnt <= cnt + LW'(1);
            if (usb_tx_last) state <= ST_TXW;
          end
        end
        ST_TXW: begin
          if (usb_abort || usb_host_ack) state <= ST_IDLE;
        end
        ST_RX: begin
          if (usb_abort) state <= ST_IDLE;
          else if (usb_rx_end) begin
            state    <= ST_IDLE;
            resp_v_q <= 1'b1;
            resp_q   <= RSP_ACK;
          end else if (rx_we) cnt <= cnt + LW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RAW'(0)) reg_rdata = RDW'(arm_q);
    if (reg_addr == RAW'(1)) reg_rdata = RDW'(tog_q);
    if (reg_addr == RAW'(2)) reg_rdata = RDW'(stall_q);
    if (reg_addr == RAW'(3)) reg_rdata = RDW'(pend_q);
    for (int e = 0; e < NUM_EP; e++) begin
      if (reg_addr == RAW'(8 + 4 * e))  reg_rdata = RDW'(in_ptr[e]);
      if (reg_addr == RAW'(9 + 4 * e))  reg_rdata = RDW'(in_len[e]);
      if (reg_addr == RAW'(10 + 4 * e)) reg_rdata = RDW'(out_ptr[e]);
      if (reg_addr == RAW'(11 + 4 * e)) reg_rdata = RDW'(out_len[e]);
    end
  end
endmodule

module epbuf_ctrl_chk #(
  parameter int NB = 6,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tok,
  input logic          idle,
  input logic          tok_ok,
  input logic [BW-1:0] tok_bit,
  input logic [NB-1:0] arm,
  input logic [NB-1:0] stall,
  input logic [NB-1:0] pend,
  input logic [NB-1:0] tog,
  input logic          resp_valid,
  input logic [1:0]    resp,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          abort
);
  AST_STALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    tok && idle && tok_ok && stall[tok_bit] |=> resp_valid && resp == 2'd3); // R3
  AST_NAK_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    tok && idle && tok_ok && !stall[tok_bit] && (pend[tok_bit] || !arm[tok_bit])
    |=> resp_valid && resp == 2'd2); // R4
  AST_NAK_BAD_EP: assert property (@(posedge clk) disable iff (!rst_n)
    tok && idle && !tok_ok |=> resp_valid && resp == 2'd2); // R12
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & arm) == '0); // R5
  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) & ~(tog ^ $past(tog))) == '0); // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !abort |=> tx_valid); // R5
endmodule

bind epbuf_ctrl epbuf_ctrl_chk #(.NB(NB), .BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tok(usb_tok), .idle(in_idle), .tok_ok(tok_ok),
  .tok_bit(tok_bit), .arm(arm_q), .stall(stall_q), .pend(pend_q), .tog(tog_q),
  .resp_valid(usb_resp_valid), .resp(usb_resp), .tx_valid(usb_tx_valid),
  .tx_ready(usb_tx_ready), .abort(usb_abort)
);

// File: tb/epbuf_ctrl_tb.sv
module epbuf_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [8:0] reg_wdata = 0, reg_rdata;
  logic       cmem_we = 0;
  logic [8:0] cmem_addr = 0;
  logic [7:0] cmem_wdata = 0, cmem_rdata;
  logic       usb_tok = 0, usb_in = 0, usb_abort = 0;
  logic [1:0] usb_ep = 0, usb_resp;
  logic       usb_resp_valid, usb_data1, usb_tx_valid, usb_tx_last;
  logic [7:0] usb_tx_data;
  logic       usb_tx_ready = 1, usb_host_ack = 0, usb_rx_valid = 0, usb_rx_end = 0;
  logic [7:0] usb_rx_data = 0;
  logic       usb_irq;

  epbuf_ctrl dut_i (.*);

  int checks = 0, errors = 0;
  logic [5:0] exp_tog = '0;

  localparam bit [17:0] VEC [5] = '{
    {2'd0, 9'd0,   7'd4},
    {2'd1, 9'd100, 7'd3},
    {2'd2, 9'd510, 7'd5},
    {2'd0, 9'd4,   7'd0},
    {2'd1, 9'd103, 7'd8}
  };

  function automatic logic [7:0] pat(int a);
    return 8'((a % 512) * 7 + 3);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); reg_we = 1; reg_addr = 5'(a); reg_wdata = 9'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(int a, output logic [8:0] v);
    reg_addr = 5'(a); #1; v = reg_rdata;
  endtask

  task automatic tok(int ep, bit dir);
    @(negedge clk); usb_tok = 1; usb_ep = 2'(ep); usb_in = dir;
    @(negedge clk); usb_tok = 0;
  endtask

  task automatic mrd(int a, output logic [7:0] v);
    @(negedge clk); cmem_addr = 9'(a);
    @(negedge clk); v = cmem_rdata;
  endtask

  task automatic rx_pkt(int n, int base);
    for (int i = 0; i < n; i++) begin
      usb_rx_valid = 1; usb_rx_data = 8'(base + i);
      @(negedge clk);
    end
    usb_rx_valid = 0; usb_rx_end = 1;
    @(negedge clk); usb_rx_end = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] v;
    logic [7:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a, v); chk("R1 mask", v, 0); end
    for (int e = 0; e < 3; e++) begin
      rd(10 + 4 * e, v); chk("R1 out_ptr", v, e * 170);
      rd(8 + 4 * e, v);  chk("R1 in_ptr", v, 0);
    end
    chk("R1 irq", usb_irq, 0);
    chk("R1 resp_valid", usb_resp_valid, 0);
    chk("R1 tx_valid", usb_tx_valid, 0);

    for (int a = 0; a < 512; a++) begin
      @(negedge clk); cmem_we = 1; cmem_addr = 9'(a); cmem_wdata = pat(a);
    end
    @(negedge clk); cmem_we = 0;

    // R5 R2 R7 R8 R11: IN transfers from the vector table
    foreach (VEC[k]) begin
      int ep, ptr, len, b;
      ep = int'(VEC[k][17:16]); ptr = int'(VEC[k][15:7]); len = int'(VEC[k][6:0]);
      b = 2 * ep + 1;
      wr(8 + 4 * ep, ptr); wr(9 + 4 * ep, len);
      rd(8 + 4 * ep, v); chk("R11 in_ptr readback", v, ptr);
      rd(9 + 4 * ep, v); chk("R11 in_len readback", v, len);
      wr(0, 1 << b);
      tok(ep, 1);
      chk("R5 no handshake on accept", usb_resp_valid, 0);
      chk("R7 data1", usb_data1, exp_tog[b]);
      for (int i = 0; i < len; i++) begin
        chk("R5 tx_valid", usb_tx_valid, 1);
        chk("R5 tx_data", usb_tx_data, pat(ptr + i));
        chk("R5 tx_last", usb_tx_last, (i == len - 1) ? 1 : 0);
        @(negedge clk);
      end
      chk("R5 stream ends", usb_tx_valid, 0);
      usb_host_ack = 1; @(negedge clk); usb_host_ack = 0;
      exp_tog[b] = ~exp_tog[b];
      rd(8 + 4 * ep, v); chk("R5 ptr advance", v, (ptr + len) % 512);
      rd(9 + 4 * ep, v); chk("R5 len zero", v, 0);
      rd(0, v); chk("R5 arm cleared", v, 0);
      rd(3, v); chk("R2 pending bit position", v, 1 << b);
      rd(1, v); chk("R7 toggle flipped", v, exp_tog);
      chk("R8 irq set", usb_irq, 1);
      wr(3, 1 << b);
      chk("R8 irq cleared", usb_irq, 0);
    end

    // R11 out pointer read-only
    wr(10, 55); rd(10, v); chk("R11 out_ptr read-only", v, 0);
    wr(11, 7);  rd(11, v); chk("R11 out_len read-only", v, 0);

    // R6 OUT transfer on endpoint 1 (bit 2)
    wr(0, 4);
    tok(1, 0);
    chk("R7 data1 out", usb_data1, 0);
    rx_pkt(3, 8'h11);
    chk("R6 ack valid", usb_resp_valid, 1);
    chk("R6 ack code", usb_resp, 1);
    exp_tog[2] = 1'b1;
    rd(14, v); chk("R6 out_ptr", v, 173);
    rd(15, v); chk("R6 out_len", v, 3);
    rd(0, v);  chk("R6 arm cleared", v, 0);
    rd(3, v);  chk("R6 pending bit2", v, 4);
    rd(1, v);  chk("R7 toggle out", v, exp_tog);
    for (int i = 0; i < 3; i++) begin mrd(170 + i, m); chk("R6 rx_mem", m, 8'h11 + i); end

    // R4 pending forces NAK, data ignored
    wr(0, 4);
    tok(1, 0);
    chk("R4 nak valid", usb_resp_valid, 1);
    chk("R4 nak code", usb_resp, 2);
    rx_pkt(1, 8'hA5);
    chk("R4 no ack after data", usb_resp_valid, 0);
    rd(14, v); chk("R4 out_ptr unchanged", v, 173);
    rd(15, v); chk("R4 out_len unchanged", v, 3);
    rd(0, v);  chk("R4 arm kept", v, 4);
    rd(3, v);  chk("R4 pending kept", v, 4);
    mrd(173, m); checks++;
    if (m === 8'hA5) begin errors++; $display("FAIL R4 rx_mem written actual %0h expected not a5", m); end
    tok(0, 0);
    chk("R4 unarmed nak", usb_resp, 2);
    wr(0, 0);

    // R8 partial clear
    wr(0, 8); wr(8 + 4, 300); wr(9 + 4, 1);
    tok(1, 1); @(negedge clk);
    usb_host_ack = 1; @(negedge clk); usb_host_ack = 0;
    exp_tog[3] = ~exp_tog[3];
    rd(3, v); chk("R8 two pending", v, 12);
    wr(3, 4); rd(3, v); chk("R8 w1c one bit", v, 8);
    chk("R8 irq still set", usb_irq, 1);
    wr(3, 8); chk("R8 irq clear", usb_irq, 0);

    // R3 stall priority
    wr(2, 2); wr(0, 2);
    tok(0, 1);
    chk("R3 stall valid", usb_resp_valid, 1);
    chk("R3 stall code", usb_resp, 3);
    chk("R3 no data", usb_tx_valid, 0);
    rd(0, v); chk("R3 arm untouched", v, 2);
    wr(2, 0); wr(0, 0);

    // R12 out of range endpoint
    tok(3, 1);
    chk("R12 nak valid", usb_resp_valid, 1);
    chk("R12 nak code", usb_resp, 2);

    // R9 abort then retry
    wr(8 + 4, 200); wr(9 + 4, 3); wr(0, 8);
    tok(1, 1);
    chk("R9 first byte", usb_tx_data, pat(200));
    @(negedge clk);
    usb_abort = 1; @(negedge clk); usb_abort = 0;
    chk("R9 idle after abort", usb_tx_valid, 0);
    rd(12, v); chk("R9 ptr kept", v, 200);
    rd(13, v); chk("R9 len kept", v, 3);
    rd(0, v);  chk("R9 arm kept", v, 8);
    rd(3, v);  chk("R9 no pending", v, 0);
    rd(1, v);  chk("R9 toggle kept", v, exp_tog);
    tok(1, 1);
    for (int i = 0; i < 3; i++) begin
      chk("R9 retry data", usb_tx_data, pat(200 + i));
      @(negedge clk);
    end
    usb_host_ack = 1; @(negedge clk); usb_host_ack = 0;
    exp_tog[3] = ~exp_tog[3];
    rd(12, v); chk("R9 retry ptr", v, 203);
    wr(3, 8);

    // R10 oversize OUT packet on endpoint 2 (bit 4)
    wr(0, 16);
    tok(2, 0);
    rx_pkt(66, 0);
    chk("R10 ack", usb_resp, 1);
    rd(19, v); chk("R10 len saturates", v, 64);
    rd(18, v); chk("R10 ptr", v, 404);
    mrd(403, m); chk("R10 last kept byte", m, 63);
    mrd(404, m); checks++;
    if (m === 8'd64) begin errors++; $display("FAIL R10 dropped byte stored actual %0h expected not 40", m); end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule